// File: doc/BRIEF.md
# Boot-Locked Peripheral Control Register

This block is a small register slave on a simple synchronous bus. It holds the configuration of a serial peripheral and drives each configuration field out as a registered signal. The fields are a memory sleep override, a digital loopback enable, three per-priority transmit credit thresholds, a bus transaction priority, a single-lane mode select, a prescaler select and four independent PLL enables. The block also holds a 32-bit identity/configuration word that software normally sees as read-only.

After reset, a one-time configuration window is open. During this window, boot firmware may write the identity word to set up power-on configuration. When software sets the lock bit in the control word, the identity word stops accepting writes. The lock bit cannot be cleared by software, so it stays set until the next reset. All other control fields stay writable after the lock is set.

Reads are registered. The data appears on `rd_data` in the cycle after `rd_en` is seen, and `rd_data` is zero in any cycle that follows no read.

Top module: `pcfg_regblk`

## Requirements
- R1: After reset, the control word (address 0x0) reads 0x0405_3000: sleep override 1, priority-2 threshold 1, priority-1 threshold 2, priority-0 threshold 3, and every other field 0. The identity word (address 0x4) reads ID_RESET (default 0x5A17_0001).
- R2: Control bits 23..21 and 31..27 always read as zero. Writing all ones to the control word reads back as 0x071F_FFFF.
- R3: Each control field sits at a fixed bit range of the word, and its output follows the last value written to that range:
  - bit 26: sleep override, `mem_awake`
  - bit 25: loopback, `loop_en`
  - bits 20..18: priority-2 threshold, `thr_p2`
  - bits 17..15: priority-1 threshold, `thr_p1`
  - bits 14..12: priority-0 threshold, `thr_p0`
  - bits 11..9: bus priority, `bus_prio`
  - bit 8: single-lane select, `single_lane`
  - bits 7..4: prescaler select, `presc_sel`
  - bits 3..0: PLL enables, `pll_en`
- R4: The lock bit (control bit 24, output `boot_locked`) is set by writing 1 to it. Writing 0 to it has no effect. Only reset clears it.
- R5: While the lock bit is 0, a write to the identity word is stored and read back.
- R6: While the lock bit is 1, a write to the identity word is ignored, and both the readback and `cfg_id` keep the earlier value.
- R7: A read of any address other than 0x0 and 0x4 returns zero. A write to such an address changes no register.
- R8: Read data appears on `rd_data` one cycle after `rd_en`. `rd_data` is zero in the cycle after a cycle with `rd_en` low.
- R9: After the lock bit is set, the other control fields still accept writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| mem_awake | output | 1 | Keep memories awake during shutdown |
| loop_en | output | 1 | Digital loopback enable |
| boot_locked | output | 1 | Configuration window closed |
| thr_p2 | output | 3 | Priority-2 credit threshold |
| thr_p1 | output | 3 | Priority-1 credit threshold |
| thr_p0 | output | 3 | Priority-0 credit threshold |
| bus_prio | output | 3 | Bus transaction priority |
| single_lane | output | 1 | Single-lane mode select |
| presc_sel | output | 4 | Prescaler select |
| pll_en | output | 4 | PLL enables, one bit per PLL |
| cfg_id | output | 32 | Identity/configuration word |

## Verification
The control word is tested with four write patterns, each checked by readback and at the field outputs:
- The reset pattern.
- A mixed pattern with a distinct value in every field. This catches a field that is swapped with its neighbour or placed at the wrong offset.
- All ones. This shows whether the reserved bits are masked.
- A write of zero after the lock is set. This separates a sticky lock from an ordinary writable bit.

The identity word is written once before the lock and once after it. This tells an open window apart from a closed one. Accesses to an unmapped address show whether address decoding leaks into either register.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam int unsigned DATA_W = 32;

  localparam int unsigned SLEEP_BIT  = 26;
  localparam int unsigned LOOP_BIT   = 25;
  localparam int unsigned LOCK_BIT   = 24;
  localparam int unsigned P2_LSB     = 18;
  localparam int unsigned P1_LSB     = 15;
  localparam int unsigned P0_LSB     = 12;
  localparam int unsigned PRIO_LSB   = 9;
  localparam int unsigned LANE_BIT   = 8;
  localparam int unsigned PRESC_LSB  = 4;
  localparam int unsigned PLL_LSB    = 0;
  localparam int unsigned THR_W      = 3;
  localparam int unsigned PRESC_W    = 4;
  localparam int unsigned NUM_PLL    = 4;

  // bits that hold state; everything else is reserved
  localparam logic [DATA_W-1:0] WR_MASK   = 32'h071F_FFFF;
  localparam logic [DATA_W-1:0] LOCK_MASK = 32'h0100_0000;
  localparam logic [DATA_W-1:0] CTRL_RST  =
      (32'd1 << SLEEP_BIT) | (32'd1 << P2_LSB) | (32'd2 << P1_LSB) | (32'd3 << P0_LSB);
endpackage

// File: rtl/pcfg_ctrl_reg.sv
module pcfg_ctrl_reg
  import pcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q
);
  logic [DATA_W-1:0] ctrl_nxt;

  // lock bit ORs in: software can set it but never clear it
  assign ctrl_nxt = (wdata & WR_MASK) | (ctrl_q & LOCK_MASK);

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= CTRL_RST;
    else if (wr_stb) ctrl_q <= ctrl_nxt;
  end

  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[LOCK_BIT] |=> ctrl_q[LOCK_BIT]);
endmodule

// File: rtl/pcfg_boot_reg.sv
module pcfg_boot_reg #(
  parameter int unsigned         W       = 32,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_stb,
  input  logic         locked,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value_q
);
  always_ff @(posedge clk) begin
    if (rst)                     value_q <= RST_VAL;
    else if (wr_stb && !locked)  value_q <= wdata;
  end

  // R6
  id_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(value_q));
endmodule

// File: rtl/pcfg_regblk.sv
module pcfg_regblk
  import pcfg_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] ID_ADDR   = 4'h4,
  parameter logic [31:0]       ID_RESET  = 32'h5A17_0001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  input  logic               rd_en,
  output logic [31:0]        rd_data,
  output logic               mem_awake,
  output logic               loop_en,
  output logic               boot_locked,
  output logic [THR_W-1:0]   thr_p2,
  output logic [THR_W-1:0]   thr_p1,
  output logic [THR_W-1:0]   thr_p0,
  output logic [THR_W-1:0]   bus_prio,
  output logic               single_lane,
  output logic [PRESC_W-1:0] presc_sel,
  output logic [NUM_PLL-1:0] pll_en,
  output logic [31:0]        cfg_id
);
  logic        hit_ctrl, hit_id;
  logic [31:0] ctrl_q, id_q, rd_mux;

  assign hit_ctrl = (addr == CTRL_ADDR);
  assign hit_id   = (addr == ID_ADDR);

  pcfg_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (wr_en && hit_ctrl),
    .wdata  (wr_data),
    .ctrl_q (ctrl_q)
  );

  pcfg_boot_reg #(.W(32), .RST_VAL(ID_RESET)) u_id (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_en && hit_id),
    .locked  (ctrl_q[LOCK_BIT]),
    .wdata   (wr_data),
    .value_q (id_q)
  );

  always_comb begin
    if (hit_ctrl)    rd_mux = ctrl_q;
    else if (hit_id) rd_mux = id_q;
    else             rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
    else            rd_data <= '0;
  end

  // field outputs come straight from register flops
  assign mem_awake   = ctrl_q[SLEEP_BIT];
  assign loop_en     = ctrl_q[LOOP_BIT];
  assign boot_locked = ctrl_q[LOCK_BIT];
  assign thr_p2      = ctrl_q[P2_LSB +: THR_W];
  assign thr_p1      = ctrl_q[P1_LSB +: THR_W];
  assign thr_p0      = ctrl_q[P0_LSB +: THR_W];
  assign bus_prio    = ctrl_q[PRIO_LSB +: THR_W];
  assign single_lane = ctrl_q[LANE_BIT];
  assign presc_sel   = ctrl_q[PRESC_LSB +: PRESC_W];

  for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
    assign pll_en[g] = ctrl_q[PLL_LSB + g];
  end

  assign cfg_id = id_q;

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && hit_ctrl) |=> ((rd_data & ~WR_MASK) == '0));
  // R7
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hit_ctrl && !hit_id) |=> (rd_data == '0));
  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));
  // R7
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hit_ctrl && !hit_id) |=> ($stable(ctrl_q) && $stable(id_q)));
endmodule

// File: tb/pcfg_regblk_tb_top.sv
module pcfg_regblk_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        mem_awake, loop_en, boot_locked, single_lane;
  logic [2:0]  thr_p2, thr_p1, thr_p0, bus_prio;
  logic [3:0]  presc_sel, pll_en;
  logic [31:0] cfg_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [31:0] ID_RST = 32'h5A17_0001;

  always #2.5 clk = ~clk;

  pcfg_regblk dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .mem_awake(mem_awake), .loop_en(loop_en),
    .boot_locked(boot_locked), .thr_p2(thr_p2), .thr_p1(thr_p1), .thr_p0(thr_p0),
    .bus_prio(bus_prio), .single_lane(single_lane), .presc_sel(presc_sel),
    .pll_en(pll_en), .cfg_id(cfg_id)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic bus_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    bus_rd(4'h0, v); chk("R1 ctrl reset", v, 32'h0405_3000);
    chk("R1 mem_awake", {31'd0, mem_awake}, 32'd1);
    chk("R1 thresholds", {23'd0, thr_p2, thr_p1, thr_p0}, {23'd0, 3'd1, 3'd2, 3'd3});
    chk("R1 lock", {31'd0, boot_locked}, 32'd0);
    bus_rd(4'h4, v); chk("R1 id reset", v, ID_RST);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    do_reset();
    bus_wr(4'h0, 32'h0217_79A5);
    bus_rd(4'h0, v); chk("R3 readback", v, 32'h0217_79A5);
    chk("R3 mem_awake", {31'd0, mem_awake}, 32'd0);
    chk("R3 loop_en", {31'd0, loop_en}, 32'd1);
    chk("R3 thr_p2", {29'd0, thr_p2}, 32'd5);
    chk("R3 thr_p1", {29'd0, thr_p1}, 32'd6);
    chk("R3 thr_p0", {29'd0, thr_p0}, 32'd7);
    chk("R3 bus_prio", {29'd0, bus_prio}, 32'd4);
    chk("R3 single_lane", {31'd0, single_lane}, 32'd1);
    chk("R3 presc_sel", {28'd0, presc_sel}, 32'hA);
    chk("R3 pll_en", {28'd0, pll_en}, 32'h5);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    do_reset();
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_rd(4'h0, v); chk("R2 reserved zero", v, 32'h071F_FFFF);
  endtask

  task automatic t_boot();
    logic [31:0] v;
    do_reset();
    bus_wr(4'h4, 32'h1234_ABCD);
    bus_rd(4'h4, v); chk("R5 id write open", v, 32'h1234_ABCD);
    bus_wr(4'h0, 32'h0100_0000);
    chk("R4 lock set", {31'd0, boot_locked}, 32'd1);
    bus_wr(4'h4, 32'hDEAD_BEEF);
    bus_rd(4'h4, v); chk("R6 id readback locked", v, 32'h1234_ABCD);
    chk("R6 cfg_id locked", cfg_id, 32'h1234_ABCD);
    bus_wr(4'h0, 32'h0000_0F0F);
    bus_rd(4'h0, v); chk("R4 R9 lock sticky fields writable", v, 32'h0100_0F0F);
    chk("R9 pll_en after lock", {28'd0, pll_en}, 32'hF);
    do_reset();
    chk("R4 reset clears lock", {31'd0, boot_locked}, 32'd0);
    chk("R4 reset restores id", cfg_id, ID_RST);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    do_reset();
    bus_wr(4'h8, 32'hFFFF_FFFF);
    bus_rd(4'h8, v); chk("R7 unmapped read", v, 32'h0);
    bus_rd(4'h0, v); chk("R7 ctrl untouched", v, 32'h0405_3000);
    bus_rd(4'h4, v); chk("R7 id untouched", v, ID_RST);
  endtask

  task automatic t_idle();
    logic [31:0] v;
    do_reset();
    bus_rd(4'h4, v); chk("R8 one-cycle read", v, ID_RST);
    @(negedge clk); chk("R8 idle zero", rd_data, 32'h0);
  endtask

  initial begin
    t_reset();
    t_fields();
    t_reserved();
    t_boot();
    t_unmapped();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule